// File: doc/BRIEF.md
# Timed Processor Power-Mode Sequencer

The block sets the processor's power state. It has three settled modes. In run the core is clocked and powered. In idle the core clock is held off but the logic keeps power. In sleep the gated domain is switched off. Software asks for idle or sleep with level request pins, and an external wake event brings the processor back to run. Every change of mode is timed in ticks of a slow timebase. The tick strobe is one clock cycle wide. The new mode is only shown on `mode_o` once the whole delay has passed.

The delays differ by direction. Entering or leaving idle is quick. Going into sleep from run or from idle is a staged shutdown of several equal steps, three by default. Leaving sleep is the slowest path and always goes straight to run. All durations are parameters counted in ticks. With a 10 ms tick, the defaults give 10 ms for idle entry and exit, 3 × 30 ms for sleep entry and 160 ms for sleep exit. The mode code lets a power table be looked up: nominally 400 mW in run, 50 mW in idle and 0.16 mW in sleep.

The block has only control and status pins and no data stream, so there is no valid/ready handshake. A request is acted on in the first cycle the block is settled and sees it.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the block is settled in run: `mode_o` = 0, `busy_o` = 0, `clk_en_o` = 1, `pd_en_o` = 1.
- R2: `mode_o` encodes run = 0, idle = 1 and sleep = 2, and never shows 3. During a transition it keeps the source mode, and it changes to the destination only when the transition completes.
- R3: A run-to-idle transition completes on the clock edge that samples the IDLE_IN_TICKS-th tick after the request was taken.
- R4: A wake in idle starts an idle-to-run transition, which completes on the IDLE_OUT_TICKS-th tick.
- R5: A sleep request in run or in idle starts a shutdown of SLEEP_STEPS steps of SLEEP_STEP_TICKS ticks each. The mode shows sleep only after SLEEP_STEPS × SLEEP_STEP_TICKS ticks.
- R6: A wake in sleep returns to run after SLEEP_OUT_TICKS ticks. An idle request in sleep is ignored, so sleep never goes to idle.
- R7: `busy_o` is high from the edge that takes a request until the edge that completes the transition. Requests and wake seen while busy are ignored.
- R8: When settled in run, a sleep request wins over an idle request. When settled in idle, wake wins over a sleep request. A wake while settled in run is ignored.
- R9: `clk_en_o` is high only when the block is settled in run. It drops in the cycle a transition out of run is taken.
- R10: `pd_en_o` is low only when the block is settled in sleep. It drops after the final shutdown step and rises as soon as the sleep exit starts.
- R11: Ticks count only while busy. A tick in the same cycle as the accepted request is not counted, and the mode never changes on an edge without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timebase strobe, one cycle per tick |
| idle_req_i | input | 1 | Request to enter idle |
| sleep_req_i | input | 1 | Request to enter sleep |
| wake_i | input | 1 | Wake event, returns to run |
| clk_en_o | output | 1 | Core clock enable |
| pd_en_o | output | 1 | Gated power-domain enable |
| mode_o | output | 2 | Settled mode code (0 run, 1 idle, 2 sleep) |
| busy_o | output | 1 | Transition in progress |

## Verification
The bench goes after several corner cases, and for each it is clear what a wrong design would do:
- A tick that arrives together with a request. A design that counts it would finish one tick early.
- The staged sleep entry. A design that loses a step, or restarts its timer badly between steps, would report sleep too soon or too late.
- Colliding requests. These show whether the wrong request wins, or whether a request taken while busy redirects a transition in flight.
- An idle request in sleep and a wake in run. A design that handles these wrongly would start a transition that should not exist.

A cycle-level reference model checks the `clk_en_o` and `pd_en_o` timing around entry and exit, under random stimulus as well.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_SLEEP = 2'd2
  } pwr_mode_e;
endpackage

// File: rtl/pwr_tick_timer.sv
module pwr_tick_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             tick_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  // Last tick of the loaded count: a one-cycle pulse
  assign done_o = run_q && tick_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= len_i;
      run_q <= 1'b1;
    end else if (run_q && tick_i) begin
      if (cnt_q == CNT_W'(1)) begin
        run_q <= 1'b0;
      end
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
#(
  parameter int CNT_W            = 5,
  parameter int IDLE_IN_TICKS    = 1,
  parameter int IDLE_OUT_TICKS   = 1,
  parameter int SLEEP_STEPS      = 3,
  parameter int SLEEP_STEP_TICKS = 3,
  parameter int SLEEP_OUT_TICKS  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_req_i,
  input  logic             sleep_req_i,
  input  logic             wake_i,
  input  logic             done_i,
  output logic             start_o,
  output logic [CNT_W-1:0] len_o,
  output pwr_mode_e        mode_o,
  output logic             busy_o
);
  localparam int STEP_W = (SLEEP_STEPS > 1) ? $clog2(SLEEP_STEPS) : 1;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SLEEP_STEPS - 1);

  pwr_mode_e        mode_q, dest_q, go_dest;
  logic             busy_q, go;
  logic [STEP_W-1:0] step_q;
  logic [CNT_W-1:0] go_len;
  logic             next_step;

  // Pick the transition to take when settled
  always_comb begin
    go      = 1'b0;
    go_dest = mode_q;
    go_len  = CNT_W'(SLEEP_STEP_TICKS);
    if (!busy_q) begin
      unique case (mode_q)
        MODE_RUN: begin
          if (sleep_req_i) begin
            go = 1'b1; go_dest = MODE_SLEEP; go_len = CNT_W'(SLEEP_STEP_TICKS);
          end else if (idle_req_i) begin
            go = 1'b1; go_dest = MODE_IDLE;  go_len = CNT_W'(IDLE_IN_TICKS);
          end
        end
        MODE_IDLE: begin
          if (wake_i) begin
            go = 1'b1; go_dest = MODE_RUN;   go_len = CNT_W'(IDLE_OUT_TICKS);
          end else if (sleep_req_i) begin
            go = 1'b1; go_dest = MODE_SLEEP; go_len = CNT_W'(SLEEP_STEP_TICKS);
          end
        end
        MODE_SLEEP: begin
          if (wake_i) begin
            go = 1'b1; go_dest = MODE_RUN;   go_len = CNT_W'(SLEEP_OUT_TICKS);
          end
        end
        default: ;
      endcase
    end
  end

  assign next_step = busy_q && done_i && (dest_q == MODE_SLEEP) && (step_q != LAST_STEP);
  assign start_o   = go || next_step;
  assign len_o     = go ? go_len : CNT_W'(SLEEP_STEP_TICKS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_RUN;
      dest_q <= MODE_RUN;
      busy_q <= 1'b0;
      step_q <= '0;
    end else if (go) begin
      busy_q <= 1'b1;
      dest_q <= go_dest;
      step_q <= '0;
    end else if (next_step) begin
      step_q <= step_q + STEP_W'(1);
    end else if (busy_q && done_i) begin
      mode_q <= dest_q;
      busy_q <= 1'b0;
      step_q <= '0;
    end
  end

  assign mode_o = mode_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int IDLE_IN_TICKS    = 1,
  parameter int IDLE_OUT_TICKS   = 1,
  parameter int SLEEP_STEPS      = 3,
  parameter int SLEEP_STEP_TICKS = 3,
  parameter int SLEEP_OUT_TICKS  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       idle_req_i,
  input  logic       sleep_req_i,
  input  logic       wake_i,
  output logic       clk_en_o,
  output logic       pd_en_o,
  output logic [1:0] mode_o,
  output logic       busy_o
);
  localparam int MAX_A     = (IDLE_IN_TICKS > IDLE_OUT_TICKS) ? IDLE_IN_TICKS : IDLE_OUT_TICKS;
  localparam int MAX_B     = (SLEEP_STEP_TICKS > SLEEP_OUT_TICKS) ? SLEEP_STEP_TICKS : SLEEP_OUT_TICKS;
  localparam int MAX_TICKS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic             start, done, busy;
  logic [CNT_W-1:0] len;
  pwr_mode_e        mode;

  pwr_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .len_i   (len),
    .tick_i  (tick_i),
    .done_o  (done)
  );

  pwr_mode_fsm #(
    .CNT_W            (CNT_W),
    .IDLE_IN_TICKS    (IDLE_IN_TICKS),
    .IDLE_OUT_TICKS   (IDLE_OUT_TICKS),
    .SLEEP_STEPS      (SLEEP_STEPS),
    .SLEEP_STEP_TICKS (SLEEP_STEP_TICKS),
    .SLEEP_OUT_TICKS  (SLEEP_OUT_TICKS)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle_req_i  (idle_req_i),
    .sleep_req_i (sleep_req_i),
    .wake_i      (wake_i),
    .done_i      (done),
    .start_o     (start),
    .len_o       (len),
    .mode_o      (mode),
    .busy_o      (busy)
  );

  assign mode_o   = mode;
  assign busy_o   = busy;
  assign clk_en_o = (mode == MODE_RUN) && !busy;
  assign pd_en_o  = !((mode == MODE_SLEEP) && !busy);
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       idle_req_i,
  input logic       sleep_req_i,
  input logic       wake_i,
  input logic       clk_en_o,
  input logic       pd_en_o,
  input logic [1:0] mode_o,
  input logic       busy_o
);
  p_mode_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'd3);

  p_no_sleep_to_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2) |=> (mode_o != 2'd1));

  p_busy_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !tick_i) |=> busy_o);

  p_wake_in_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0 && !busy_o && wake_i && !idle_req_i && !sleep_req_i) |=> !busy_o);

  p_clk_en_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_o |-> (mode_o == 2'd0 && !busy_o));

  p_pd_off_sleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_en_o |-> (mode_o == 2'd2 && !busy_o));

  p_no_change_without_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(mode_o));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_i      (tick_i),
  .idle_req_i  (idle_req_i),
  .sleep_req_i (sleep_req_i),
  .wake_i      (wake_i),
  .clk_en_o    (clk_en_o),
  .pd_en_o     (pd_en_o),
  .mode_o      (mode_o),
  .busy_o      (busy_o)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb_top;
  localparam int IE = 2, IX = 3, STEPS = 3, ST = 2, SX = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, idle_req = 1'b0, sleep_req = 1'b0, wake = 1'b0;
  logic clk_en, pd_en, busy;
  logic [1:0] mode;

  int checks = 0, fails = 0;
  bit chk_on = 1'b0;

  // reference model state
  int m_mode = 0, m_dest = 0, m_rem = 0;
  bit m_busy = 1'b0;

  always #4 clk = ~clk;

  pwr_mode_ctrl #(
    .IDLE_IN_TICKS(IE), .IDLE_OUT_TICKS(IX), .SLEEP_STEPS(STEPS),
    .SLEEP_STEP_TICKS(ST), .SLEEP_OUT_TICKS(SX)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .idle_req_i(idle_req),
    .sleep_req_i(sleep_req), .wake_i(wake), .clk_en_o(clk_en),
    .pd_en_o(pd_en), .mode_o(mode), .busy_o(busy)
  );

  function automatic bit exp_clk_en(int md, bit bz);
    return (md == 0) && !bz;
  endfunction

  function automatic bit exp_pd_en(int md, bit bz);
    return !((md == 2) && !bz);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model of the requirements
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode <= 0; m_busy <= 1'b0; m_dest <= 0; m_rem <= 0;
    end else if (m_busy) begin
      if (tick) begin
        if (m_rem == 1) begin m_busy <= 1'b0; m_mode <= m_dest; end
        else m_rem <= m_rem - 1;
      end
    end else begin
      case (m_mode)
        0: if (sleep_req) begin m_busy <= 1'b1; m_dest <= 2; m_rem <= STEPS*ST; end
           else if (idle_req) begin m_busy <= 1'b1; m_dest <= 1; m_rem <= IE; end
        1: if (wake) begin m_busy <= 1'b1; m_dest <= 0; m_rem <= IX; end
           else if (sleep_req) begin m_busy <= 1'b1; m_dest <= 2; m_rem <= STEPS*ST; end
        2: if (wake) begin m_busy <= 1'b1; m_dest <= 0; m_rem <= SX; end
        default: ;
      endcase
    end
  end

  // continuous comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (chk_on) begin
      check(mode == 2'(m_mode), "R2 mode", mode, m_mode);
      check(busy == m_busy, "R7 busy", busy, m_busy);
      check(clk_en == exp_clk_en(m_mode, m_busy), "R9 clk_en", clk_en, exp_clk_en(m_mode, m_busy));
      check(pd_en == exp_pd_en(m_mode, m_busy), "R10 pd_en", pd_en, exp_pd_en(m_mode, m_busy));
    end
  end

  task automatic pulse(bit i, bit s, bit w, bit t);
    @(negedge clk);
    idle_req = i; sleep_req = s; wake = w; tick = t;
    @(negedge clk);
    idle_req = 1'b0; sleep_req = 1'b0; wake = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic expect_state(string tag, int md, bit bz);
    check(mode == 2'(md), tag, mode, md);
    check(busy == bz, tag, busy, bz);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0 (run hung)");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_on = 1'b1;
    // R1 reset state
    check(mode == 2'd0, "R1 mode", mode, 0);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(clk_en == 1'b1, "R1 clk_en", clk_en, 1);
    check(pd_en == 1'b1, "R1 pd_en", pd_en, 1);

    // R8: sleep beats idle in run; R5 staged sleep entry
    pulse(1, 1, 0, 0);
    expect_state("R8 sleep wins", 0, 1);
    check(clk_en == 1'b0, "R9 clk_en drops", clk_en, 0);
    ticks(STEPS*ST - 1);
    expect_state("R5 not yet asleep", 0, 1);
    check(pd_en == 1'b1, "R10 pd_en before last step", pd_en, 1);
    ticks(1);
    expect_state("R5 asleep", 2, 0);
    check(pd_en == 1'b0, "R10 pd_en off", pd_en, 0);

    // R6: idle request in sleep ignored; slow exit
    pulse(1, 0, 0, 0);
    expect_state("R6 idle req in sleep", 2, 0);
    pulse(0, 0, 1, 0);
    check(pd_en == 1'b1, "R10 pd_en on at exit", pd_en, 1);
    ticks(SX - 1);
    expect_state("R6 still leaving", 2, 1);
    ticks(1);
    expect_state("R6 back in run", 0, 0);

    // R8: wake in run ignored
    pulse(0, 0, 1, 0);
    expect_state("R8 wake in run", 0, 0);

    // R11: tick with the request is not counted; R3 idle entry
    pulse(1, 0, 0, 1);
    ticks(IE - 1);
    expect_state("R11 same-cycle tick", 0, 1);
    ticks(1);
    expect_state("R3 in idle", 1, 0);

    // R8: wake beats sleep in idle; R4 fast exit
    pulse(0, 1, 1, 0);
    ticks(IX - 1);
    expect_state("R4 leaving idle", 1, 1);
    ticks(1);
    expect_state("R4 run from idle", 0, 0);

    // R7: request while busy ignored
    pulse(1, 0, 0, 0);
    pulse(0, 1, 0, 0);
    ticks(IE);
    expect_state("R7 busy ignores sleep req", 1, 0);

    // R5: sleep from idle
    pulse(0, 1, 0, 0);
    ticks(STEPS*ST - 1);
    expect_state("R5 idle->sleep pending", 1, 1);
    ticks(1);
    expect_state("R5 idle->sleep done", 2, 0);
    pulse(0, 0, 1, 0);
    ticks(SX);

    // random phase, checked by the model
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      tick      = ($urandom % 2) == 0;
      idle_req  = ($urandom % 8) == 0;
      sleep_req = ($urandom % 16) == 0;
      wake      = ($urandom % 8) == 0;
    end
    @(negedge clk);
    idle_req = 1'b0; sleep_req = 1'b0; wake = 1'b0; tick = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule